// File: doc/BRIEF.md
# Integer 2D FDTD Grid Engine

This block keeps a whole two-dimensional electromagnetic grid on chip and advances it by a fixed number of leapfrog time steps with no outside help. Each cell holds six signed 32-bit field words: the electric components Ex, Ey, Ez and the magnetic components Bx, By, Bz. The fields are stored in rescaled units, so every cell update is a small stencil of integer additions and subtractions. The datapath has no multiplier and no divider, and results wrap modulo 2^32.

A host loads the starting fields through a simple word port while the engine is idle. It then pulses `start` and waits for the one-cycle `done` pulse, after which it reads the results back through the same port. Each time step makes two passes over the grid, always in the same order. The first pass updates every E word. The second pass updates every B word from the freshly written E. Both passes visit cells with x incrementing fastest and one cell per clock. Cells on the outer edge of the grid are never written by the engine, which models a perfectly conducting wall.

The controller is a four-state machine:
- **IDLE**: the host port is open. `start` moves the machine to **E_SWEEP**.
- **E_SWEEP**: updates E. On the last cell it moves to **B_SWEEP**.
- **B_SWEEP**: updates B. On the last cell it returns to **E_SWEEP** if steps remain, and otherwise moves to **FINISH**.
- **FINISH**: raises `done` for one cycle and returns to **IDLE**.

Top module: `fdtd_grid_engine`

## Requirements
- R1: After reset, `busy` and `done` are both low.
- R2: While idle, a write with `host_we` high stores `host_wdata` into the field picked by `host_sel` at cell `host_addr` (cell index = y*NX + x). `host_rdata` shows the same field combinationally. The `host_sel` encoding is: bit 2 = 0 for E and 1 for B; bits 1:0 = 0 for x, 1 for y, 2 for z. A select with bits 1:0 equal to 3, or an address of NX*NY or above, writes nothing and reads 0.
- R3: While `busy` is high, host writes have no effect and `host_rdata` is 0.
- R4: For an interior cell, the E pass computes Ex += Bz(x,y+1) - Bz(x,y); Ey -= Bz(x+1,y) - Bz(x,y); Ez -= (Bx(x,y+1) - Bx(x,y)) - (By(x+1,y) - By(x,y)).
- R5: For an interior cell, the B pass computes Bx -= Ez(x,y) - Ez(x,y-1); By += Ez(x,y) - Ez(x-1,y); Bz -= (Ex(x,y) - Ex(x,y-1)) - (Ey(x,y) - Ey(x-1,y)).
- R6: Within a step, every E word is updated before any B word, and the B pass uses the new E values.
- R7: Cells with x = 0, x = NX-1, y = 0 or y = NY-1 keep all six fields unchanged through a run.
- R8: All sums and differences wrap modulo 2^32 in two's complement.
- R9: A `start` seen while idle raises `busy` on the next cycle. A run lasts exactly 2*NX*NY*NSTEPS sweep cycles, then one cycle with `done` high. `start` while busy is ignored.
- R10: `done` is high for exactly one cycle. On the following cycle `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted when idle) |
| busy | output | 1 | High from run start through the done cycle |
| done | output | 1 | One-cycle pulse at the end of a run |
| host_we | input | 1 | Host write enable |
| host_sel | input | 3 | Field select: bit 2 picks E/B, bits 1:0 pick x/y/z |
| host_addr | input | $clog2(NX*NY) | Cell index y*NX + x |
| host_wdata | input | 32 | Host write word |
| host_rdata | output | 32 | Host read word, 0 while busy or when the select/address is invalid |

## Verification
The hardest effect to isolate from the ports is the influence of one cell's value on its neighbours across both passes and several steps. It includes edge cells that must never change even though interior cells read them. The bench therefore loads an all-zero grid with a single nonzero word, once for every field and every cell, runs the engine, and compares all six fields of every cell against an arithmetic model of the same stencils. A second run uses large pseudo-random values to force wrap-around. During that run the bench also pokes an edge cell and pulses `start`, to show that the host port and the start input are both inert while the engine is busy.

// File: rtl/fdtd_pkg.sv
package fdtd_pkg;
    localparam int FIELD_W = 32;

    typedef logic signed [FIELD_W-1:0] field_t;

    typedef struct packed {
        field_t x;
        field_t y;
        field_t z;
    } vec3_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ESWEEP = 2'd1,
        ST_BSWEEP = 2'd2,
        ST_FINISH = 2'd3
    } eng_state_t;
endpackage

// File: rtl/fdtd_cell_counter.sv
module fdtd_cell_counter #(
    parameter int NX = 8,
    parameter int NY = 8,
    localparam int NCELL = NX * NY,
    localparam int AW = $clog2(NCELL),
    localparam int XW = (NX > 1) ? $clog2(NX) : 1,
    localparam int YW = (NY > 1) ? $clog2(NY) : 1
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          adv,
    output logic [AW-1:0] addr,
    output logic          interior,
    output logic          last
);
    logic [XW-1:0] x_q;
    logic [YW-1:0] y_q;
    logic [AW-1:0] a_q;

    logic x_end;
    logic y_end;

    assign x_end    = (x_q == XW'(NX - 1));
    assign y_end    = (y_q == YW'(NY - 1));
    assign last     = x_end && y_end;
    assign interior = (x_q != '0) && !x_end && (y_q != '0) && !y_end;
    assign addr     = a_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            x_q <= '0;
            y_q <= '0;
            a_q <= '0;
        end else if (adv) begin
            if (last) begin
                x_q <= '0;
                y_q <= '0;
                a_q <= '0;
            end else begin
                a_q <= a_q + AW'(1);
                if (x_end) begin
                    x_q <= '0;
                    y_q <= y_q + YW'(1);
                end else begin
                    x_q <= x_q + XW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/fdtd_vec_bank.sv
module fdtd_vec_bank
    import fdtd_pkg::*;
#(
    parameter int NCELL = 64,
    localparam int AW = $clog2(NCELL)
) (
    input  logic          clk,
    input  logic          host_we,
    input  logic [1:0]    host_comp,
    input  logic [AW-1:0] host_addr,
    input  field_t        host_wdata,
    output field_t        host_rdata,
    input  logic          upd_we,
    input  logic [AW-1:0] upd_addr,
    input  vec3_t         upd_data,
    input  logic [AW-1:0] rd_addr_c,
    input  logic [AW-1:0] rd_addr_y,
    input  logic [AW-1:0] rd_addr_x,
    output vec3_t         rd_c,
    output vec3_t         rd_y,
    output vec3_t         rd_x
);
    vec3_t mem [NCELL];

    always_ff @(posedge clk) begin
        if (upd_we) begin
            mem[upd_addr] <= upd_data;
        end else if (host_we) begin
            unique case (host_comp)
                2'd0:    mem[host_addr].x <= host_wdata;
                2'd1:    mem[host_addr].y <= host_wdata;
                2'd2:    mem[host_addr].z <= host_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (host_comp)
            2'd0:    host_rdata = mem[host_addr].x;
            2'd1:    host_rdata = mem[host_addr].y;
            2'd2:    host_rdata = mem[host_addr].z;
            default: host_rdata = '0;
        endcase
    end

    assign rd_c = mem[rd_addr_c];
    assign rd_y = mem[rd_addr_y];
    assign rd_x = mem[rd_addr_x];
endmodule

// File: rtl/fdtd_curl.sv
module fdtd_curl
    import fdtd_pkg::*;
(
    input  logic  phase_b,
    input  vec3_t own,
    input  vec3_t oc,
    input  vec3_t ny,
    input  vec3_t nx,
    output vec3_t upd
);
    field_t dy_x, dy_z, dx_y, dx_z;
    logic   unused_lanes;

    always_comb begin
        if (phase_b) begin
            dy_x = oc.x - ny.x;
            dy_z = oc.z - ny.z;
            dx_y = oc.y - nx.y;
            dx_z = oc.z - nx.z;
            upd.x = own.x - dy_z;
            upd.y = own.y + dx_z;
        end else begin
            dy_x = ny.x - oc.x;
            dy_z = ny.z - oc.z;
            dx_y = nx.y - oc.y;
            dx_z = nx.z - oc.z;
            upd.x = own.x + dy_z;
            upd.y = own.y - dx_z;
        end
        upd.z = own.z - (dy_x - dx_y);
    end

    assign unused_lanes = ^{ny.y, nx.x};
endmodule

// File: rtl/fdtd_grid_engine.sv
module fdtd_grid_engine
    import fdtd_pkg::*;
#(
    parameter int NX = 8,
    parameter int NY = 8,
    parameter int NSTEPS = 100,
    localparam int NCELL = NX * NY,
    localparam int AW = $clog2(NCELL),
    localparam int SW = $clog2(NSTEPS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          done,
    input  logic          host_we,
    input  logic [2:0]    host_sel,
    input  logic [AW-1:0] host_addr,
    input  logic [31:0]   host_wdata,
    output logic [31:0]   host_rdata
);
    localparam logic [AW-1:0] NXA = AW'(NX);

    eng_state_t state_q, state_d;
    logic [SW-1:0] step_q;

    logic          sweeping, phase_b, interior, last;
    logic [AW-1:0] addr, addr_y, addr_x;

    vec3_t e_c, e_y, e_x, b_c, b_y, b_x;
    vec3_t own, oc, ny, nx, upd;
    field_t e_h, b_h;

    logic host_ok;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_ESWEEP;
            ST_ESWEEP: if (last)  state_d = ST_BSWEEP;
            ST_BSWEEP: if (last)  state_d = (step_q == SW'(NSTEPS - 1)) ? ST_FINISH : ST_ESWEEP;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        busy     = 1'b1;
        done     = 1'b0;
        sweeping = 1'b0;
        phase_b  = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy = 1'b0;
            ST_ESWEEP: sweeping = 1'b1;
            ST_BSWEEP: begin sweeping = 1'b1; phase_b = 1'b1; end
            ST_FINISH: done = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || state_q == ST_IDLE) step_q <= '0;
        else if (state_q == ST_BSWEEP && last) step_q <= step_q + SW'(1);
    end

    fdtd_cell_counter #(.NX(NX), .NY(NY)) u_cnt (
        .clk(clk), .clr(!sweeping), .adv(sweeping),
        .addr(addr), .interior(interior), .last(last)
    );

    // Neighbour addresses: forward in E pass, backward in B pass; edges read self
    assign addr_y = !interior ? addr : (phase_b ? addr - NXA : addr + NXA);
    assign addr_x = !interior ? addr : (phase_b ? addr - AW'(1) : addr + AW'(1));

    assign host_ok = !busy && (host_sel[1:0] != 2'd3) &&
                     ({1'b0, host_addr} < (AW+1)'(NCELL));

    fdtd_vec_bank #(.NCELL(NCELL)) u_ebank (
        .clk(clk),
        .host_we(host_we && host_ok && !host_sel[2]), .host_comp(host_sel[1:0]),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(e_h),
        .upd_we(sweeping && !phase_b && interior), .upd_addr(addr), .upd_data(upd),
        .rd_addr_c(addr), .rd_addr_y(addr_y), .rd_addr_x(addr_x),
        .rd_c(e_c), .rd_y(e_y), .rd_x(e_x)
    );

    fdtd_vec_bank #(.NCELL(NCELL)) u_bbank (
        .clk(clk),
        .host_we(host_we && host_ok && host_sel[2]), .host_comp(host_sel[1:0]),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(b_h),
        .upd_we(sweeping && phase_b && interior), .upd_addr(addr), .upd_data(upd),
        .rd_addr_c(addr), .rd_addr_y(addr_y), .rd_addr_x(addr_x),
        .rd_c(b_c), .rd_y(b_y), .rd_x(b_x)
    );

    assign own = phase_b ? b_c : e_c;
    assign oc  = phase_b ? e_c : b_c;
    assign ny  = phase_b ? e_y : b_y;
    assign nx  = phase_b ? e_x : b_x;

    fdtd_curl u_curl (
        .phase_b(phase_b), .own(own), .oc(oc), .ny(ny), .nx(nx), .upd(upd)
    );

    assign host_rdata = !host_ok ? '0 : (host_sel[2] ? b_h : e_h);
endmodule

// File: rtl/fdtd_grid_checker.sv
module fdtd_grid_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic [31:0] host_rdata
);
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    assert_done_in_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_start_takes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_rdata_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (host_rdata == 32'd0));
endmodule

bind fdtd_grid_engine fdtd_grid_checker u_grid_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .done(done), .host_rdata(host_rdata)
);

// File: tb/tb_fdtd_grid_engine.sv
module tb_fdtd_grid_engine;
    localparam int NX = 5;
    localparam int NY = 4;
    localparam int NSTEPS = 3;
    localparam int NCELL = NX * NY;
    localparam int AW = $clog2(NCELL);
    localparam int RUNLEN = 2 * NCELL * NSTEPS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy, done;
    logic host_we = 1'b0;
    logic [2:0] host_sel = '0;
    logic [AW-1:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;

    int checks = 0;
    int errors = 0;
    int m [6][NCELL];
    int unsigned seed = 32'h1234_5678;

    always #4 clk = ~clk;

    fdtd_grid_engine #(.NX(NX), .NY(NY), .NSTEPS(NSTEPS)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .host_we(host_we), .host_sel(host_sel), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] sel_of(input int f);
        return (f < 3) ? 3'(f) : 3'(f + 1);
    endfunction

    task automatic hwrite(input logic [2:0] s, input int a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_sel = s; host_addr = AW'(a); host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hread(input logic [2:0] s, input int a, output logic [31:0] d);
        @(negedge clk);
        host_sel = s; host_addr = AW'(a);
        #1 d = host_rdata;
    endtask

    function automatic int unsigned lcg();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    function automatic bit inner(input int i);
        int x, y;
        x = i % NX; y = i / NX;
        return (x > 0) && (x < NX - 1) && (y > 0) && (y < NY - 1);
    endfunction

    // Behavioural model of one full run: E pass then B pass, NSTEPS times (R4 R5 R6 R7 R8)
    task automatic model_run();
        for (int s = 0; s < NSTEPS; s++) begin
            for (int i = 0; i < NCELL; i++) if (inner(i)) begin
                m[0][i] = m[0][i] + (m[5][i+NX] - m[5][i]);
                m[1][i] = m[1][i] - (m[5][i+1] - m[5][i]);
                m[2][i] = m[2][i] - ((m[3][i+NX] - m[3][i]) - (m[4][i+1] - m[4][i]));
            end
            for (int i = 0; i < NCELL; i++) if (inner(i)) begin
                m[3][i] = m[3][i] - (m[2][i] - m[2][i-NX]);
                m[4][i] = m[4][i] + (m[2][i] - m[2][i-1]);
                m[5][i] = m[5][i] - ((m[0][i] - m[0][i-NX]) - (m[1][i] - m[1][i-1]));
            end
        end
    endtask

    task automatic load_grid();
        for (int f = 0; f < 6; f++)
            for (int i = 0; i < NCELL; i++) hwrite(sel_of(f), i, m[f][i]);
    endtask

    task automatic compare_grid(input string req);
        logic [31:0] d;
        for (int f = 0; f < 6; f++)
            for (int i = 0; i < NCELL; i++) begin
                hread(sel_of(f), i, d);
                chk(req, d, m[f][i]);
            end
    endtask

    // Runs the engine; with poke set, writes an edge cell and pulses start mid-run
    task automatic run_engine(input bit poke);
        int cnt;
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        cnt = 0;
        forever begin
            @(negedge clk);
            if (done) break;
            if (poke && cnt == 3) begin
                host_we = 1'b1; host_sel = 3'd0; host_addr = '0;
                host_wdata = 32'h5A5A_5A5A; start = 1'b1;
                #1 chk("R3 rdata while busy", host_rdata, 32'd0);
                chk("R9 busy during run", {31'd0, busy}, 32'd1);
            end else begin
                host_we = 1'b0; start = 1'b0;
            end
            cnt++;
            if (cnt > RUNLEN + 10) break;
        end
        host_we = 1'b0; start = 1'b0;
        chk("R9 run length", cnt, RUNLEN);
        chk("R9 done at end", {31'd0, done}, 32'd1);
        @(negedge clk);
        chk("R10 done one cycle", {31'd0, done}, 32'd0);
        chk("R10 idle after done", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        #(8 * 190000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        chk("R1 busy at reset", {31'd0, busy}, 32'd0);
        chk("R1 done at reset", {31'd0, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", {31'd0, busy}, 32'd0);

        // R2: distinct word in every field and cell, then read back
        for (int f = 0; f < 6; f++)
            for (int i = 0; i < NCELL; i++) m[f][i] = (f << 12) + i * 7 - 50;
        load_grid();
        compare_grid("R2 host readback");
        hwrite(3'd3, 2, 32'hDEAD_BEEF);
        hwrite(3'd7, 2, 32'hDEAD_BEEF);
        hread(3'd3, 2, d); chk("R2 invalid sel read", d, 32'd0);
        hread(3'd7, 2, d); chk("R2 invalid sel read", d, 32'd0);
        hwrite(3'd0, NCELL + 3, 32'hDEAD_BEEF);
        hread(3'd0, NCELL + 3, d); chk("R2 out of range read", d, 32'd0);
        compare_grid("R2 invalid write ignored");

        // R8 R3 R9: pseudo-random large values, mid-run poke of an edge cell
        for (int f = 0; f < 6; f++)
            for (int i = 0; i < NCELL; i++) m[f][i] = int'(lcg());
        load_grid();
        run_engine(1'b1);
        model_run();
        compare_grid("R8 R3 R7 random wrap run");

        // Near-exhaustive single-impulse sweep (R4 R5 R6 R7)
        for (int f = 0; f < 6; f++)
            for (int c = 0; c < NCELL; c++) begin
                for (int g = 0; g < 6; g++)
                    for (int i = 0; i < NCELL; i++) m[g][i] = 0;
                m[f][c] = (c % 2 == 0) ? 1000 + f : -37 - c;
                load_grid();
                run_engine(1'b0);
                model_run();
                compare_grid("R4 R5 R6 R7 impulse run");
            end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule